// File: doc/BRIEF.md
# Three-Tier Vectored Interrupt Controller

This block collects thirteen active-low interrupt request lines for a small 8-bit processor core. It decides which request may interrupt the code that is running and hands that request's fixed vector address to the core. Twelve lines are ordinary sources. Each ordinary source has its own enable bit, a priority bit (low or high) and a trigger-mode bit (falling edge or low level). The thirteenth line is a super-priority source. A shared global enable does not mask it. It is usable only while the bus-mode input selects the multiplexed configuration.

The block keeps three active-level flags: low, high and super. These flags record which handlers are currently nested. A request is offered to the core only when its level is above the highest active level. The core accepts an offer with `cpu_ack` and ends a handler with `cpu_reti`.

The control is a two-state machine. In IDLE nothing is offered. The IDLE-to-OFFER transition ("raise") happens when a qualifying candidate exists. In OFFER, `vec_valid` is high and `vec_addr` carries the winner. OFFER-to-OFFER ("refresh") re-registers the current best candidate every cycle. OFFER-to-IDLE happens either on `cpu_ack` ("accept": the active level is pushed and the winner's edge flag is cleared) or when no candidate remains ("withdraw").

Top module: `tri_level_irq_ctrl`

## Requirements
- R1: After reset, `vec_valid` is 0 and no level is active.
- R2: Source index i (bit i of `req_n`) has a fixed vector. Indices 0..4 map to 0x03, 0x0B, 0x13, 0x1B, 0x23. Indices 5..11 map to 0x33, 0x3B, 0x43, 0x4B, 0x53, 0x5B, 0x63. Index 12, the super line, maps to 0x6B.
- R3: Among pending requests of the same priority, the winner is the first in this index order: 5, 0, 6, 1, 7, 2, 8, 3, 9, 4, 10, 11.
- R4: An eligible high-priority request (`src_hi[i]`=1) always wins over any eligible low-priority one.
- R5: With `trig_edge[i]`=1, a 1-to-0 transition of `req_n[i]` sets a pending flag. Acceptance of that source's vector clears the flag. If `req_n[i]` first reads low at clock edge k, `vec_valid` rises after edge k+3, provided nothing blocks the request.
- R6: With `trig_edge[i]`=0, the source is pending exactly while its synchronised line is low. Acceptance does not clear it.
- R7: An ordinary source is eligible only when `src_en[i]`=1 and `glob_en`=1. The super line ignores both of these enables.
- R8: While `mux_mode`=0, the super line is never offered, and any edge it sees is discarded rather than kept for later.
- R9: While the low level is active, no low-priority request is offered, but high-priority and super requests are offered.
- R10: While the high level is active, only the super request is offered. While the super level is active, nothing is offered.
- R11: `cpu_reti` clears the highest active level flag. It is ignored in a cycle where an offer is accepted. `cpu_ack` is ignored while `vec_valid` is 0.
- R12: `vec_valid` and `vec_addr` are registered. They follow the candidate set one cycle later. `vec_valid` is 0 in the cycle after an accepted `cpu_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 13 | Active-low request lines; bit 12 is the super line |
| trig_edge | input | 13 | Per line: 1 = falling edge, 0 = low level |
| src_en | input | 12 | Per ordinary source enable |
| src_hi | input | 12 | Per ordinary source priority: 1 = high |
| glob_en | input | 1 | Global enable for the ordinary sources |
| mux_mode | input | 1 | 1 = super line usable |
| cpu_ack | input | 1 | Core accepts the offered vector |
| cpu_reti | input | 1 | Core ends the current handler |
| vec_valid | output | 1 | A vector is offered |
| vec_addr | output | 8 | Offered vector address |

## Verification
A request line that goes low before edge k yields an offer after edge k+3: two synchroniser stages, one pending flag or delayed sample, and the registered offer. An accepted acknowledge removes `vec_valid` after the very next edge. The effect of a return on the nesting shows one edge after that. The bench drives every input at the falling clock edge and runs a behavioural reference model at the rising edge. It compares `vec_valid` and `vec_addr` against that model at each falling edge. Directed checks count these same edge distances before they sample fixed expected vectors.

// File: rtl/tlic_pkg.sv
package tlic_pkg;

    localparam int TLIC_NUM_ORD = 12;
    localparam int TLIC_IDX_W   = 4;

    typedef enum logic [1:0] {
        LVL_NONE  = 2'd0,
        LVL_LOW   = 2'd1,
        LVL_HIGH  = 2'd2,
        LVL_SUPER = 2'd3
    } lvl_e;

    typedef enum logic {
        ST_IDLE,
        ST_OFFER
    } ofr_state_e;

    // Tie-break rank of a source: lower rank wins within one level.
    // The added sources interleave with the legacy ones.
    function automatic logic [3:0] rank_of(input logic [3:0] idx);
        if (idx < 4'd5) begin
            return 4'((idx << 1) + 4'd1);
        end else if (idx < 4'd10) begin
            return 4'((idx - 4'd5) << 1);
        end else begin
            return idx;
        end
    endfunction

    // Vector address: legacy sources at 8*i+3, the rest shifted up by 8.
    function automatic logic [7:0] vec_of(input logic [3:0] idx);
        logic [7:0] base;
        base = {1'b0, idx, 3'b000};
        if (idx < 4'd5) begin
            return base + 8'd3;
        end else begin
            return base + 8'd11;
        end
    endfunction

endpackage

// File: rtl/tlic_sync_edge.sv
module tlic_sync_edge #(
    parameter int NUM_LINES   = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_n,
    input  logic [NUM_LINES-1:0] edge_mode,
    input  logic [NUM_LINES-1:0] ack_clr,
    input  logic [NUM_LINES-1:0] hold_clr,
    output logic [NUM_LINES-1:0] pend
);

    localparam int LAST = SYNC_STAGES;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [LAST:0] chain;
        logic          flag;
        logic          fall;

        // chain[0] is the newest sample, chain[LAST] the oldest
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[LAST-1:0], line_n[g]};
            end
        end

        assign fall = chain[LAST] & ~chain[LAST-1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag <= 1'b0;
            end else if (!edge_mode[g] || hold_clr[g]) begin
                flag <= 1'b0;
            end else begin
                flag <= (flag & ~ack_clr[g]) | fall;
            end
        end

        assign pend[g] = edge_mode[g] ? flag : ~chain[LAST];
    end

endmodule

// File: rtl/tlic_arbiter.sv
module tlic_arbiter
    import tlic_pkg::*;
#(
    parameter int NUM_ORD = 12,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_ORD-1:0] pend_ord,
    input  logic [NUM_ORD-1:0] src_en,
    input  logic [NUM_ORD-1:0] src_hi,
    input  logic               glob_en,
    input  logic               super_req,
    input  lvl_e               cur_lvl,
    output logic               found,
    output logic [IDX_W-1:0]   win_idx,
    output lvl_e               win_lvl
);

    logic [NUM_ORD-1:0] elig;
    logic [NUM_ORD-1:0] hi_m;
    logic [NUM_ORD-1:0] lo_m;
    logic               hi_found;
    logic               lo_found;
    logic [IDX_W-1:0]   hi_idx;
    logic [IDX_W-1:0]   lo_idx;
    logic [3:0]         hi_rank;
    logic [3:0]         lo_rank;

    assign elig = pend_ord & src_en & {NUM_ORD{glob_en}};
    assign hi_m = elig & src_hi;
    assign lo_m = elig & ~src_hi;

    always_comb begin
        hi_found = 1'b0;
        lo_found = 1'b0;
        hi_idx   = '0;
        lo_idx   = '0;
        hi_rank  = 4'hF;
        lo_rank  = 4'hF;
        for (int i = 0; i < NUM_ORD; i++) begin
            if (hi_m[i] && (rank_of(4'(i)) < hi_rank)) begin
                hi_rank  = rank_of(4'(i));
                hi_idx   = IDX_W'(i);
                hi_found = 1'b1;
            end
            if (lo_m[i] && (rank_of(4'(i)) < lo_rank)) begin
                lo_rank  = rank_of(4'(i));
                lo_idx   = IDX_W'(i);
                lo_found = 1'b1;
            end
        end
    end

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = LVL_NONE;
        if (super_req && (cur_lvl != LVL_SUPER)) begin
            found   = 1'b1;
            win_idx = IDX_W'(NUM_ORD);
            win_lvl = LVL_SUPER;
        end else if (hi_found && (cur_lvl < LVL_HIGH)) begin
            found   = 1'b1;
            win_idx = hi_idx;
            win_lvl = LVL_HIGH;
        end else if (lo_found && (cur_lvl == LVL_NONE)) begin
            found   = 1'b1;
            win_idx = lo_idx;
            win_lvl = LVL_LOW;
        end
    end

endmodule

// File: rtl/tlic_level_stack.sv
module tlic_level_stack
    import tlic_pkg::*;
#(
    parameter int NUM_LVL = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  lvl_e               push_lvl,
    input  logic               pop,
    output logic [NUM_LVL-1:0] act,
    output lvl_e               top_lvl
);

    logic [NUM_LVL-1:0] act_nxt;
    int                 top_pos;

    always_comb begin
        top_pos = 0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (act[i]) begin
                top_pos = i;
            end
        end
    end

    always_comb begin
        act_nxt = act;
        if (push) begin
            if (push_lvl != LVL_NONE) begin
                act_nxt[int'(push_lvl) - 1] = 1'b1;
            end
        end else if (pop && (act != '0)) begin
            act_nxt[top_pos] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act <= '0;
        end else begin
            act <= act_nxt;
        end
    end

    assign top_lvl = (act == '0) ? LVL_NONE : lvl_e'(top_pos + 1);

endmodule

// File: rtl/tri_level_irq_ctrl.sv
module tri_level_irq_ctrl
    import tlic_pkg::*;
#(
    parameter int NUM_ORD     = 12,
    parameter int SYNC_STAGES = 2,
    parameter int VEC_W       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ORD:0]   req_n,
    input  logic [NUM_ORD:0]   trig_edge,
    input  logic [NUM_ORD-1:0] src_en,
    input  logic [NUM_ORD-1:0] src_hi,
    input  logic               glob_en,
    input  logic               mux_mode,
    input  logic               cpu_ack,
    input  logic               cpu_reti,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_addr
);

    localparam int NUM_SRC = NUM_ORD + 1;
    localparam int IDX_W   = TLIC_IDX_W;
    localparam int SUP     = NUM_ORD;
    localparam int NUM_LVL = 3;

    ofr_state_e         state;
    ofr_state_e         nxt;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ack_clr;
    logic [NUM_SRC-1:0] hold_clr;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    lvl_e               win_lvl;
    logic [IDX_W-1:0]   win_q;
    lvl_e               lvl_q;
    logic               accept;
    logic [NUM_LVL-1:0] act_lvls;
    lvl_e               cur_lvl;

    always_comb begin
        hold_clr      = '0;
        hold_clr[SUP] = ~mux_mode;
    end

    always_comb begin
        ack_clr = '0;
        if (accept) begin
            ack_clr[win_q] = 1'b1;
        end
    end

    tlic_sync_edge #(
        .NUM_LINES   (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_n    (req_n),
        .edge_mode (trig_edge),
        .ack_clr   (ack_clr),
        .hold_clr  (hold_clr),
        .pend      (pend)
    );

    tlic_arbiter #(
        .NUM_ORD (NUM_ORD),
        .IDX_W   (IDX_W)
    ) u_arb (
        .pend_ord  (pend[NUM_ORD-1:0]),
        .src_en    (src_en),
        .src_hi    (src_hi),
        .glob_en   (glob_en),
        .super_req (mux_mode & pend[SUP]),
        .cur_lvl   (cur_lvl),
        .found     (found),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    tlic_level_stack #(
        .NUM_LVL (NUM_LVL)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_lvl (lvl_q),
        .pop      (cpu_reti),
        .act      (act_lvls),
        .top_lvl  (cur_lvl)
    );

    assign accept = (state == ST_OFFER) && cpu_ack;

    // Next-state logic: raise, refresh, accept, withdraw
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = found ? ST_OFFER : ST_IDLE;
            ST_OFFER: begin
                if (cpu_ack) begin
                    nxt = ST_IDLE;
                end else begin
                    nxt = found ? ST_OFFER : ST_IDLE;
                end
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register with the offered winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            win_q <= '0;
            lvl_q <= LVL_NONE;
        end else begin
            state <= nxt;
            if (nxt == ST_OFFER) begin
                win_q <= win_idx;
                lvl_q <= win_lvl;
            end
        end
    end

    // Outputs
    always_comb begin
        vec_valid = (state == ST_OFFER);
        vec_addr  = VEC_W'(vec_of(4'(win_q)));
    end

endmodule

// File: rtl/tlic_chk.sv
module tlic_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mux_mode,
    input logic       glob_en,
    input logic       cpu_ack,
    input logic       cpu_reti,
    input logic       vec_valid,
    input logic [7:0] vec_addr,
    input logic [2:0] act
);

    // R2: only table addresses are ever offered
    p_vec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((vec_addr[2:0] == 3'b011) && (vec_addr <= 8'h6B) && (vec_addr != 8'h2B)));

    // R7: with the global enable off only the super vector may appear
    p_glob_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> (!vec_valid || (vec_addr == 8'h6B)));

    // R8: super vector only after the bus mode allowed it
    p_super_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && (vec_addr == 8'h6B)) |-> $past(mux_mode));

    // R10: an active super level blocks every offer
    p_super_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        act[2] |=> !vec_valid);

    // R10: an active high level lets only the super vector through
    p_high_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (act[1] && !act[2]) |=> (!vec_valid || (vec_addr == 8'h6B)));

    // R12: offer drops right after acceptance
    p_ack_drops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && vec_valid) |=> !vec_valid);

    // R9: acceptance adds exactly one active level
    p_ack_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && vec_valid) |=> ($countones(act) == $countones($past(act)) + 1));

    // R11: a return without acceptance removes exactly one level
    p_reti_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_reti && !(cpu_ack && vec_valid) && (act != 3'b000))
        |=> ($countones(act) == $countones($past(act)) - 1));

endmodule

bind tri_level_irq_ctrl tlic_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mux_mode  (mux_mode),
    .glob_en   (glob_en),
    .cpu_ack   (cpu_ack),
    .cpu_reti  (cpu_reti),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .act       (act_lvls)
);

// File: tb/tri_level_irq_ctrl_tb_top.sv
module tri_level_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] req_n = '1;
    logic [12:0] trig_edge = '1;
    logic [11:0] src_en = '1;
    logic [11:0] src_hi = '0;
    logic        glob_en = 1'b1;
    logic        mux_mode = 1'b1;
    logic        cpu_ack = 1'b0;
    logic        cpu_reti = 1'b0;
    logic        vec_valid;
    logic [7:0]  vec_addr;

    int    n_checks = 0;
    int    n_errors = 0;
    int    wd = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    tri_level_irq_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (req_n),
        .trig_edge (trig_edge),
        .src_en    (src_en),
        .src_hi    (src_hi),
        .glob_en   (glob_en),
        .mux_mode  (mux_mode),
        .cpu_ack   (cpu_ack),
        .cpu_reti  (cpu_reti),
        .vec_valid (vec_valid),
        .vec_addr  (vec_addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- reference model ----------------
    int          vec_tab[13] = '{8'h03, 8'h0B, 8'h13, 8'h1B, 8'h23, 8'h33, 8'h3B,
                                 8'h43, 8'h4B, 8'h53, 8'h5B, 8'h63, 8'h6B};
    int          tie_order[12] = '{5, 0, 6, 1, 7, 2, 8, 3, 9, 4, 10, 11};
    logic [12:0] hist[$];
    logic [12:0] m_flag;
    logic [2:0]  m_act;
    bit          m_valid;
    int          m_idx;
    int          m_lvl;
    logic [12:0] m_pend;
    logic [12:0] m_fall;
    int          m_cur;
    bit          m_found;
    int          m_widx;
    int          m_wlvl;
    bit          m_accept;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist    = '{13'h1FFF, 13'h1FFF, 13'h1FFF};
            m_flag  = '0;
            m_act   = '0;
            m_valid = 1'b0;
            m_idx   = 0;
            m_lvl   = 0;
        end else begin
            m_fall = hist[2] & ~hist[1];
            for (int b = 0; b < 13; b++) begin
                m_pend[b] = trig_edge[b] ? m_flag[b] : ~hist[2][b];
            end
            m_cur   = m_act[2] ? 3 : (m_act[1] ? 2 : (m_act[0] ? 1 : 0));
            m_found = 1'b0;
            m_widx  = 0;
            m_wlvl  = 0;
            if (mux_mode && m_pend[12] && m_cur < 3) begin
                m_found = 1'b1; m_widx = 12; m_wlvl = 3;
            end
            if (!m_found && m_cur < 2) begin
                for (int k = 0; k < 12; k++) begin
                    if (!m_found && glob_en && src_en[tie_order[k]] &&
                        src_hi[tie_order[k]] && m_pend[tie_order[k]]) begin
                        m_found = 1'b1; m_widx = tie_order[k]; m_wlvl = 2;
                    end
                end
            end
            if (!m_found && m_cur < 1) begin
                for (int k = 0; k < 12; k++) begin
                    if (!m_found && glob_en && src_en[tie_order[k]] &&
                        !src_hi[tie_order[k]] && m_pend[tie_order[k]]) begin
                        m_found = 1'b1; m_widx = tie_order[k]; m_wlvl = 1;
                    end
                end
            end
            m_accept = m_valid && cpu_ack;
            for (int b = 0; b < 13; b++) begin
                if (!trig_edge[b] || (b == 12 && !mux_mode)) begin
                    m_flag[b] = 1'b0;
                end else begin
                    m_flag[b] = (m_flag[b] && !(m_accept && m_idx == b)) || m_fall[b];
                end
            end
            if (m_accept) begin
                m_act[m_lvl - 1] = 1'b1;
                m_valid = 1'b0;
            end else begin
                if (cpu_reti) begin
                    if (m_act[2]) m_act[2] = 1'b0;
                    else if (m_act[1]) m_act[1] = 1'b0;
                    else m_act[0] = 1'b0;
                end
                m_valid = m_found;
                if (m_found) begin
                    m_idx = m_widx;
                    m_lvl = m_wlvl;
                end
            end
            hist.push_front(req_n);
            void'(hist.pop_back());
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (vec_valid !== m_valid) begin
                n_errors++;
                $display("FAIL %s model vec_valid actual=%0b expected=%0b", cur_tag, vec_valid, m_valid);
            end
            if (m_valid) begin
                n_checks++;
                if (vec_addr !== 8'(vec_tab[m_idx])) begin
                    n_errors++;
                    $display("FAIL %s model vec_addr actual=%02h expected=%02h", cur_tag, vec_addr, vec_tab[m_idx]);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk); cpu_ack = 1'b1;
        @(negedge clk); cpu_ack = 1'b0;
    endtask

    task automatic do_reti();
        @(negedge clk); cpu_reti = 1'b1;
        @(negedge clk); cpu_reti = 1'b0;
    endtask

    task automatic pulse(input int i);
        @(negedge clk); req_n[i] = 1'b0;
        cyc(2);
        req_n[i] = 1'b1;
    endtask

    task automatic wait_offer(input string tag, input int exp);
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            if (vec_valid) break;
        end
        chk({tag, " valid"}, int'(vec_valid), 1);
        chk({tag, " addr"}, int'(vec_addr), exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd == WD_LIMIT && !done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        cyc(3);
        rst_n = 1'b1;
        cur_tag = "R1";
        cyc(2);
        chk("R1 idle after reset", int'(vec_valid), 0);

        // R2 / R5 / R12: every source alone, edge triggered
        cur_tag = "R2";
        for (int i = 0; i < 13; i++) begin
            @(negedge clk); req_n[i] = 1'b0;
            cyc(3);
            chk("R12 not yet offered", int'(vec_valid), 0);
            cyc(1);
            chk("R5 offer after k+3", int'(vec_valid), 1);
            chk("R2 vector", int'(vec_addr), vec_tab[i]);
            req_n[i] = 1'b1;
            do_ack();
            chk("R12 drop after ack", int'(vec_valid), 0);
            cyc(3);
            chk("R5 flag cleared by ack", int'(vec_valid), 0);
            do_reti();
        end

        // R3 / R6 / R9: all ordinary sources level triggered and low
        cur_tag = "R3";
        trig_edge[11:0] = '0;
        req_n[11:0] = '0;
        wait_offer("R3 first in order", 8'h33);
        do_ack();
        cyc(4);
        chk("R9 low blocks low", int'(vec_valid), 0);
        do_reti();
        wait_offer("R6 level stays pending", 8'h33);
        src_en[5] = 1'b0;
        cyc(2);
        chk("R3 second in order", int'(vec_addr), 8'h03);
        src_en[0] = 1'b0;
        cyc(2);
        chk("R3 third in order", int'(vec_addr), 8'h3B);

        // R4 / R10
        cur_tag = "R4";
        src_hi[11] = 1'b1;
        cyc(2);
        chk("R4 high beats low", int'(vec_addr), 8'h63);
        do_ack();
        cur_tag = "R10";
        cyc(3);
        chk("R10 high blocks low", int'(vec_valid), 0);
        @(negedge clk); req_n[12] = 1'b0;
        wait_offer("R10 super preempts high", 8'h6B);
        do_ack();
        cyc(4);
        chk("R10 super blocks all", int'(vec_valid), 0);
        req_n[12] = 1'b1;
        do_reti();
        cyc(3);
        chk("R10 high still blocks", int'(vec_valid), 0);
        cur_tag = "R11";
        do_reti();
        wait_offer("R11 pop reopens", 8'h63);
        src_hi[11] = 1'b0;
        cyc(2);
        chk("R3 back to low order", int'(vec_addr), 8'h3B);
        src_en = '1;
        cyc(2);
        chk("R3 full order", int'(vec_addr), 8'h33);

        // R9: low handler preempted by high
        cur_tag = "R9";
        do_ack();
        src_hi[4] = 1'b1;
        wait_offer("R9 high preempts low", 8'h23);
        do_ack();
        do_reti();
        do_reti();
        src_hi = '0;

        // R7
        cur_tag = "R7";
        glob_en = 1'b0;
        cyc(3);
        chk("R7 global mask", int'(vec_valid), 0);
        @(negedge clk); req_n[12] = 1'b0;
        wait_offer("R7 super unmasked", 8'h6B);
        req_n[12] = 1'b1;
        do_ack();
        do_reti();
        glob_en = 1'b1;
        src_en = '0;
        cyc(3);
        chk("R7 per source mask", int'(vec_valid), 0);
        src_en = '1;
        wait_offer("R7 unmasked again", 8'h33);
        req_n[11:0] = '1;
        cyc(5);
        chk("R6 level release", int'(vec_valid), 0);

        // R8
        cur_tag = "R8";
        trig_edge = '1;
        mux_mode = 1'b0;
        pulse(12);
        cyc(6);
        chk("R8 super off", int'(vec_valid), 0);
        mux_mode = 1'b1;
        cyc(4);
        chk("R8 edge discarded", int'(vec_valid), 0);
        mux_mode = 1'b0;
        trig_edge[12] = 1'b0;
        req_n[12] = 1'b0;
        cyc(5);
        chk("R8 level super off", int'(vec_valid), 0);
        mux_mode = 1'b1;
        wait_offer("R8 level super on", 8'h6B);
        do_ack();
        req_n[12] = 1'b1;
        cyc(4);
        do_reti();
        cyc(3);
        chk("R8 released", int'(vec_valid), 0);
        trig_edge[12] = 1'b1;

        // R11
        cur_tag = "R11";
        do_ack();
        pulse(0);
        wait_offer("R11 stray ack ignored", 8'h03);
        @(negedge clk); cpu_ack = 1'b1; cpu_reti = 1'b1;
        @(negedge clk); cpu_ack = 1'b0; cpu_reti = 1'b0;
        pulse(1);
        cyc(5);
        chk("R11 reti ignored with ack", int'(vec_valid), 0);
        do_reti();
        wait_offer("R11 reti pops", 8'h0B);
        do_ack();
        do_reti();
        do_reti();
        pulse(2);
        wait_offer("R11 empty reti harmless", 8'h13);
        do_ack();
        do_reti();
        cyc(4);
        chk("R1 quiet at end", int'(vec_valid), 0);

        finish_run();
    end

endmodule